// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block carries out one clause-22 management exchange with an Ethernet PHY each time software stores a 32-bit management word. The word already holds every field of the frame: start code, opcode, PHY address, register address, turnaround and 16 data bits. The engine sends a run of 32 ones as a preamble and then shifts the stored word out unchanged, most significant bit first, on the serial data line. It generates the management clock itself.

For a read, the engine stops driving the data line at the turnaround. It samples the PHY's reply on each rising clock edge of the 16 data bits and writes the reply over the low half of the management word. At the end of the exchange it raises a completion flag in an event word. Software clears the flag by writing a one to that bit. A speed setting gives the clock divisor, held one bit to the left, so the management clock runs at the system clock divided by twice the divisor. A target of about 2.5 MHz gives roughly 25 µs per exchange. A divisor of zero stops the management clock.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset the management clock, data output and output enable are all low, and the management word and event word read zero.
- R2: A management-word write while idle loads the word and starts an exchange in the next cycle. A write during an exchange is ignored, so the word read back is unchanged.
- R3: The speed value bits [DIV_W:1] form the divisor d and bit 0 is ignored. Each management clock half-period lasts d system clocks. Every bit starts with the low half.
- R4: The data output carries 32 ones and then word bits 31 down to 0. Each bit starts at the falling edge of the management clock and holds through the high half.
- R5: When word bits 29:28 are 2'b10 (read), the output enable drops from the first turnaround bit (word bit 17) to the end of the exchange. With any other opcode it stays high through all 64 bits. It is low while idle.
- R6: In a read, the input is sampled at the rising edge of each of the 16 data bits. The first sample is the most significant. The 16-bit result replaces word bits 15:0 at completion, and bits 31:16 are kept. A non-read leaves the word unchanged.
- R7: Completion sets bit 23 of the event word exactly 128*d cycles after the exchange starts. All other event bits read zero.
- R8: An event-word write with bit 23 set clears the flag. A write with bit 23 clear has no effect. If a clear and a completion fall in the same cycle, the completion wins.
- R9: With a divisor of zero the management clock output is low and the exchange pauses. It resumes where it stopped once a nonzero divisor returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameWrEn | input | 1 | Write strobe for the management word |
| frameWrData | input | 32 | Management word to load |
| frameRdData | output | 32 | Current management word |
| evtWrEn | input | 1 | Write strobe for the event word |
| evtWrData | input | 32 | Write-1-to-clear mask for the event word |
| evtRdData | output | 32 | Event word, completion flag at bit 23 |
| speedWrEn | input | 1 | Write strobe for the speed setting |
| speedWrData | input | DIV_W+1 | Speed setting (divisor in bits DIV_W:1) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Serial data driven to the PHY |
| mdioOe | output | 1 | Output enable for mdioOut |
| mdioIn | input | 1 | Serial data returned by the PHY |

## Verification
On every cycle the assertions check four things: the data output holds steady through each high clock phase, the management word stays frozen during an exchange, the completion flag follows the finishing fall, and a paused exchange keeps its bit position. Behaviours that depend on the data itself are left to the bench scenarios and its per-cycle reference model. These are the exact 128*d duration, the release point of the enable for reads against writes, the sampled reply value and its merge into the low half, and the precedence of completion over a simultaneous clear.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;
  localparam int PRE_LEN  = 32;
  localparam int FRM_LEN  = 32;
  localparam int TOT_LEN  = PRE_LEN + FRM_LEN;
  localparam int IDX_W    = $clog2(TOT_LEN);
  localparam int DATA_W   = 16;
  localparam int TA_HI    = 17;
  localparam int OP_HI    = 29;
  localparam int EVT_BIT  = 23;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef struct packed {
    logic             start;
    logic             rise;
    logic             fall;
    logic             finish;
    logic             busy;
    logic [IDX_W-1:0] bitIdx;
  } mdioStrobeT;
endpackage

// File: rtl/mdio_eng_ctrl.sv
module mdio_eng_ctrl
  import mdio_eng_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameWrEn,
  input  logic             speedWrEn,
  input  logic [DIV_W:0]   speedWrData,
  output mdioStrobeT       strobe,
  output logic             mdc,
  output logic [DIV_W-1:0] divisor
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOT_LEN - 1);

  logic [DIV_W:0]   speedReg;
  logic [DIV_W-1:0] divCnt;
  logic             mdcQ;
  logic             busyQ;
  logic [IDX_W-1:0] bitIdxQ;
  logic             running;
  logic             tick;
  logic             startNow;
  logic             riseNow;
  logic             fallNow;
  logic             finishNow;

  assign divisor   = speedReg[DIV_W:1];
  assign running   = busyQ && (divisor != '0);
  assign tick      = running && (divCnt >= (divisor - 1'b1));
  assign startNow  = frameWrEn && !busyQ;
  assign riseNow   = tick && !mdcQ;
  assign fallNow   = tick && mdcQ;
  assign finishNow = fallNow && (bitIdxQ == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      speedReg <= '0;
    end else if (speedWrEn) begin
      speedReg <= speedWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      divCnt  <= '0;
      mdcQ    <= 1'b0;
      bitIdxQ <= '0;
    end else if (startNow) begin
      busyQ   <= 1'b1;
      divCnt  <= '0;
      mdcQ    <= 1'b0;
      bitIdxQ <= '0;
    end else if (running) begin
      if (tick) begin
        divCnt <= '0;
        mdcQ   <= ~mdcQ;
        if (fallNow) begin
          if (finishNow) begin
            busyQ <= 1'b0;
          end else begin
            bitIdxQ <= bitIdxQ + 1'b1;
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign mdc = mdcQ && (divisor != '0);

  always_comb begin
    strobe.start  = startNow;
    strobe.rise   = riseNow;
    strobe.fall   = fallNow;
    strobe.finish = finishNow;
    strobe.busy   = busyQ;
    strobe.bitIdx = bitIdxQ;
  end
endmodule

// File: rtl/mdio_eng_dpath.sv
module mdio_eng_dpath
  import mdio_eng_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  mdioStrobeT  strobe,
  input  logic [31:0] frameWrData,
  input  logic        evtWrEn,
  input  logic [31:0] evtWrData,
  input  logic        mdioIn,
  output logic [31:0] frameRdData,
  output logic [31:0] evtRdData,
  output logic        mdioOut,
  output logic        mdioOe
);
  localparam logic [IDX_W-1:0] FRM_IDX  = IDX_W'(PRE_LEN);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_LEN + FRM_LEN - 1 - TA_HI);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(TOT_LEN - DATA_W);

  logic [31:0]       frameReg;
  logic [DATA_W-1:0] capReg;
  logic              evtQ;
  logic              isRead;
  logic              inFrame;
  logic              releaseZone;
  logic              sampleZone;
  logic [4:0]        fIdx;

  assign isRead      = frameReg[OP_HI -: 2] == OP_READ;
  assign inFrame     = strobe.bitIdx >= FRM_IDX;
  assign releaseZone = strobe.bitIdx >= TA_IDX;
  assign sampleZone  = strobe.bitIdx >= DATA_IDX;
  assign fIdx        = 5'(TOT_LEN - 1 - int'(strobe.bitIdx));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '0;
    end else if (strobe.start) begin
      frameReg <= frameWrData;
    end else if (strobe.finish && isRead) begin
      frameReg[DATA_W-1:0] <= capReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg <= '0;
    end else if (strobe.rise && isRead && sampleZone) begin
      capReg <= {capReg[DATA_W-2:0], mdioIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtQ <= 1'b0;
    end else if (strobe.finish) begin
      evtQ <= 1'b1;
    end else if (evtWrEn && evtWrData[EVT_BIT]) begin
      evtQ <= 1'b0;
    end
  end

  always_comb begin
    evtRdData          = '0;
    evtRdData[EVT_BIT] = evtQ;
  end

  assign frameRdData = frameReg;
  assign mdioOut     = strobe.busy && (inFrame ? frameReg[fIdx] : 1'b1);
  assign mdioOe      = strobe.busy && !(isRead && releaseZone);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_eng_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameWrEn,
  input  logic [31:0]  frameWrData,
  output logic [31:0]  frameRdData,
  input  logic         evtWrEn,
  input  logic [31:0]  evtWrData,
  output logic [31:0]  evtRdData,
  input  logic         speedWrEn,
  input  logic [DIV_W:0] speedWrData,
  output logic         mdc,
  output logic         mdioOut,
  output logic         mdioOe,
  input  logic         mdioIn
);
  mdioStrobeT       strobe;
  logic [DIV_W-1:0] divisor;

  mdio_eng_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .frameWrEn   (frameWrEn),
    .speedWrEn   (speedWrEn),
    .speedWrData (speedWrData),
    .strobe      (strobe),
    .mdc         (mdc),
    .divisor     (divisor)
  );

  mdio_eng_dpath u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .frameWrData (frameWrData),
    .evtWrEn     (evtWrEn),
    .evtWrData   (evtWrData),
    .mdioIn      (mdioIn),
    .frameRdData (frameRdData),
    .evtRdData   (evtRdData),
    .mdioOut     (mdioOut),
    .mdioOe      (mdioOe)
  );
endmodule

// File: rtl/mdio_frame_engine_chk.sv
module mdio_frame_engine_chk
  import mdio_eng_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input mdioStrobeT       strobe,
  input logic [DIV_W-1:0] divisor,
  input logic             mdc,
  input logic             mdioOut,
  input logic             mdioOe,
  input logic [31:0]      frameRdData,
  input logic [31:0]      evtRdData,
  input logic             evtWrEn,
  input logic [31:0]      evtWrData
);
  p_out_hold_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> $stable(mdioOut));

  p_oe_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.busy |-> !mdioOe);

  p_frame_frozen_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.busy && $past(strobe.busy)) |-> $stable(frameRdData));

  p_evt_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> evtRdData[EVT_BIT]);

  p_evt_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (evtWrEn && evtWrData[EVT_BIT] && !strobe.finish) |=> !evtRdData[EVT_BIT]);

  p_pause_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(divisor) == '0 && $past(strobe.busy) && strobe.busy) |-> $stable(strobe.bitIdx));

  p_edges_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.start, strobe.rise, strobe.fall}));
endmodule

bind mdio_frame_engine mdio_frame_engine_chk #(.DIV_W(DIV_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .strobe      (strobe),
  .divisor     (divisor),
  .mdc         (mdc),
  .mdioOut     (mdioOut),
  .mdioOe      (mdioOe),
  .frameRdData (frameRdData),
  .evtRdData   (evtRdData),
  .evtWrEn     (evtWrEn),
  .evtWrData   (evtWrData)
);

// File: tb/mdio_frame_engine_tb_top.sv
`timescale 1ns/1ps
module mdio_frame_engine_tb_top;
  localparam int DIV_W = 6;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         frameWrEn = 1'b0;
  logic [31:0]  frameWrData = '0;
  logic [31:0]  frameRdData;
  logic         evtWrEn = 1'b0;
  logic [31:0]  evtWrData = '0;
  logic [31:0]  evtRdData;
  logic         speedWrEn = 1'b0;
  logic [DIV_W:0] speedWrData = '0;
  logic         mdc;
  logic         mdioOut;
  logic         mdioOe;
  logic         mdioIn = 1'b1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // reference model state
  bit          mBusy = 1'b0;
  int          mT = 0;
  int          mBit = 0;
  logic [31:0] mFrame = '0;
  bit          mEvt = 1'b0;
  logic [15:0] mCap = '0;
  logic [DIV_W:0] mSpeed = '0;
  logic [15:0] resp = '0;

  always #2 clk = ~clk;

  mdio_frame_engine #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rstN(rstN),
    .frameWrEn(frameWrEn), .frameWrData(frameWrData), .frameRdData(frameRdData),
    .evtWrEn(evtWrEn), .evtWrData(evtWrData), .evtRdData(evtRdData),
    .speedWrEn(speedWrEn), .speedWrData(speedWrData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit modelRead();
    return mFrame[29:28] == 2'b10;
  endfunction

  // model advances on every rising edge
  always @(posedge clk) begin
    int d;
    bit startNow;
    bit fin;
    if (!rstN) begin
      mBusy = 0; mT = 0; mBit = 0; mFrame = '0; mEvt = 0; mCap = '0; mSpeed = '0;
    end else begin
      d = int'(mSpeed >> 1);
      startNow = frameWrEn && !mBusy;
      fin = 0;
      if (mBusy && d != 0) begin
        mT++;
        mBit = mT / (2 * d);
        if ((mT % (2 * d)) == d && modelRead() && mBit >= 48)
          mCap = {mCap[14:0], mdioIn};
        if (mT == 128 * d) begin
          fin = 1;
          mBusy = 0;
          if (modelRead()) mFrame[15:0] = mCap;
        end
      end
      if (fin) mEvt = 1;
      else if (evtWrEn && evtWrData[23]) mEvt = 0;
      if (startNow) begin
        mBusy = 1; mT = 0; mBit = 0; mFrame = frameWrData;
      end
      if (speedWrEn) mSpeed = speedWrData;
    end
  end

  // compare on every falling edge, then present the PHY reply bit
  always @(negedge clk) begin
    int d;
    bit eMdc;
    bit eOut;
    bit eOe;
    d = int'(mSpeed >> 1);
    eMdc = mBusy && d != 0 && ((mT % (2 * d)) >= d);
    eOut = mBusy && ((mBit < 32) ? 1'b1 : mFrame[63 - mBit]);
    eOe  = mBusy && !(modelRead() && mBit >= 46);
    if (!finished) begin
      chk("R3 mdc", 32'(mdc), 32'(eMdc));
      chk("R4 mdioOut", 32'(mdioOut), 32'(eOut));
      chk("R5 mdioOe", 32'(mdioOe), 32'(eOe));
      chk("R6 frame word", frameRdData, mFrame);
      chk("R7 event word", evtRdData, 32'(mEvt) << 23);
    end
    mdioIn <= (mBusy && mBit >= 48 && mBit < 64) ? resp[63 - mBit] : 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wrFrame(input logic [31:0] v);
    @(negedge clk); frameWrEn = 1'b1; frameWrData = v;
    @(negedge clk); frameWrEn = 1'b0;
  endtask

  task automatic wrSpeed(input logic [DIV_W:0] v);
    @(negedge clk); speedWrEn = 1'b1; speedWrData = v;
    @(negedge clk); speedWrEn = 1'b0;
  endtask

  task automatic wrEvt(input logic [31:0] v);
    @(negedge clk); evtWrEn = 1'b1; evtWrData = v;
    @(negedge clk); evtWrEn = 1'b0; evtWrData = '0;
  endtask

  task automatic waitEvt(output int n);
    n = 0;
    while (!evtRdData[23] && n < 2000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    int n;
    logic [31:0] rdWord;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 mdc", 32'(mdc), 0);
    chk("R1 oe", 32'(mdioOe), 0);
    chk("R1 out", 32'(mdioOut), 0);
    chk("R1 frame", frameRdData, 0);
    chk("R1 event", evtRdData, 0);
    rstN = 1'b1;

    // write exchange, divisor 2
    wrSpeed(7'd4);
    wrFrame({2'b01, 2'b01, 5'd5, 5'd3, 2'b10, 16'hA5C3});
    waitEvt(n);
    chk("R7 duration 128*d", 32'(n), 256);
    chk("R6 write keeps word", frameRdData, {2'b01, 2'b01, 5'd5, 5'd3, 2'b10, 16'hA5C3});
    wrEvt(32'hFF7F_FFFF);
    chk("R8 clear without bit23 ignored", evtRdData, 32'h0080_0000);
    wrEvt(32'h0080_0000);
    chk("R8 clear with bit23", evtRdData, 0);

    // read exchange, divisor 3 (speed bit 0 set and ignored)
    wrSpeed(7'd7);
    resp = 16'hBEEF;
    rdWord = {2'b01, 2'b10, 5'd17, 5'd2, 2'b10, 16'h0000};
    wrFrame(rdWord);
    repeat (50) @(negedge clk);
    wrFrame(32'hFFFF_FFFF);
    chk("R2 write while busy ignored", frameRdData, rdWord);
    waitEvt(n);
    chk("R6 read data merged", frameRdData, {rdWord[31:16], 16'hBEEF});
    wrEvt(32'h0080_0000);

    // read with a pause, divisor 1
    wrSpeed(7'd2);
    resp = 16'h1234;
    rdWord = {2'b01, 2'b10, 5'd1, 5'd31, 2'b10, 16'h5555};
    wrFrame(rdWord);
    repeat (100) @(negedge clk);
    wrSpeed(7'd0);
    repeat (10) @(negedge clk);
    chk("R9 mdc low while paused", 32'(mdc), 0);
    chk("R9 no completion while paused", evtRdData, 0);
    wrSpeed(7'd2);
    waitEvt(n);
    chk("R6 read after pause", frameRdData, {rdWord[31:16], 16'h1234});
    wrEvt(32'h0080_0000);

    // clear held across completion: completion wins
    @(negedge clk); evtWrEn = 1'b1; evtWrData = 32'h0080_0000;
    wrFrame({2'b01, 2'b01, 5'd9, 5'd4, 2'b10, 16'h0F0F});
    waitEvt(n);
    chk("R8 completion beats clear", evtRdData, 32'h0080_0000);
    @(negedge clk);
    chk("R8 held clear then clears", evtRdData, 0);
    evtWrEn = 1'b0; evtWrData = '0;
    repeat (4) @(negedge clk);
    chk("R5 idle oe", 32'(mdioOe), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule